// File: doc/BRIEF.md
# Lazy-Normalising Floating Adder

This block adds or subtracts two floating-point numbers. Each number has an 18-bit two's-complement fractional mantissa and an 18-bit signed integer exponent. The accumulator pair (mantissa, exponent) is one operand and a two-word store operand is the other. The block supports two operations:

- Add, which returns accumulator + operand.
- Negate-and-add, which returns operand − accumulator.

Normalisation is deferred to the start of the operation. While the exponents are being aligned, the operand with the larger exponent is left-shifted only as far as needed to make it standardised. The other mantissa is then right-shifted, one place per clock, until the exponent gap is closed. The two mantissas are added, and a one-bit overflow of the sum is repaired. The result is never renormalised, so a zero or small mantissa keeps whatever exponent the alignment left it.

The block is sequential. A one-cycle `start` launches an operation and `busy` stays high while alignment runs. A one-cycle `done` pulse marks the moment the result registers are updated. Those registers hold their value until the next operation completes.

Top module: `lazy_fadd`

## Requirements
- R1: After synchronous reset, `busy` and `done` are 0, and `res_man` and `res_exp` are 0.
- R2: When `busy` is low, a high `start` captures the operands and `op_sub`, and `busy` is high from the next cycle. A `start` that arrives while `busy` is high is ignored and does not change the result.
- R3: `done` is high for exactly one cycle, and `busy` is low in that cycle. `res_man` and `res_exp` hold their value until the next `done`.
- R4: With `op_sub`=0, the result is accumulator + operand, computed with the alignment of R6/R7 and the overflow handling of R8.
- R5: With `op_sub`=1, the accumulator mantissa is first negated and then added to the operand. If that mantissa is the most negative value (18'h20000), the negation gives 18'h10000 and the accumulator exponent is incremented by one.
- R6: The operand with the larger exponent is kept, and its exponent becomes the working exponent. On equal exponents the (possibly negated) accumulator is kept. Each alignment step then does one of two things:
  - While the kept mantissa is not standardised (bit 17 equals bit 16), the step shifts it left one place and lowers the working exponent by one. At most 17 such shifts are made.
  - Otherwise, the step arithmetic-right-shifts the other mantissa by one place.
- R7: Right shifts stop after 18 places, even when the exponent gap is larger. The shifted mantissa is then all sign bits, so the result is the same as for the full gap. A kept mantissa of zero is left-shifted 17 times.
- R8: If the two aligned mantissas have the same sign and the 18-bit sum has the other sign, the sum is shifted right one place with the operands' sign put into bit 17, and the exponent is incremented.
- R9: The sum is not left-normalised. For example, equal operands under negate-and-add give mantissa 0 with the working exponent.
- R10: Exponents are compared in 19 bits, so a gap between the most positive and most negative exponents (e.g. 18'h1FFFF and 18'h20000) selects the right larger operand.
- R11: The number of clock edges from the edge that captures `start` up to `done` equals 1 + left shifts + right shifts. This is 1 when the exponents are equal and at most 36.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only while idle) |
| op_sub | input | 1 | 0 = add, 1 = negate-and-add |
| acc_man | input | 18 | Accumulator mantissa |
| acc_exp | input | 18 | Accumulator exponent |
| opd_man | input | 18 | Store operand mantissa |
| opd_exp | input | 18 | Store operand exponent |
| busy | output | 1 | Alignment in progress |
| done | output | 1 | One-cycle pulse: result registers updated |
| res_man | output | 18 | Result mantissa |
| res_exp | output | 18 | Result exponent |

## Verification
The hardest situation to reach from the ports is the longest alignment. That case needs a zero kept mantissa together with an exponent gap well beyond 18 places, so that both the 17-step left-shift limit and the 18-step right-shift limit are reached. The stimulus table includes that case and a case with a gap of 2^18−1 between extreme exponents. A directed test measures the full 36-cycle latency of the longest case, and during that window it fires a second `start` carrying different operands. The most-negative negation and both overflow polarities come from dedicated table rows whose expected values were worked out by hand from the requirements.

// File: rtl/fadd_pkg.sv
package fadd_pkg;

    localparam int MAN_W = 18;
    localparam int EXP_W = 18;
    localparam int GAP_W = EXP_W + 1;

    typedef logic [MAN_W-1:0]        man_t;
    typedef logic [EXP_W-1:0]        exp_t;
    typedef logic signed [GAP_W-1:0] gap_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ALIGN = 1'b1
    } fstate_t;

    typedef struct packed {
        man_t man;
        exp_t ex;
    } fnum_t;

    // Standardised: the two top mantissa bits differ.
    function automatic logic is_std(input man_t m);
        return m[MAN_W-1] ^ m[MAN_W-2];
    endfunction

    function automatic logic is_minneg(input man_t m);
        return m == {1'b1, {(MAN_W-1){1'b0}}};
    endfunction

    function automatic gap_t widen(input exp_t e);
        return gap_t'({e[EXP_W-1], e});
    endfunction

endpackage

// File: rtl/fadd_prep.sv
module fadd_prep
    import fadd_pkg::*;
(
    input  logic  op_sub,
    input  fnum_t acc,
    input  fnum_t opd,
    output fnum_t keep,
    output man_t  other_man,
    output gap_t  gap
);
    fnum_t acc_n;
    gap_t  acc_w;
    gap_t  opd_w;

    // Optional negation of the accumulator mantissa.
    always_comb begin
        acc_n = acc;
        if (op_sub) begin
            if (is_minneg(acc.man)) begin
                acc_n.man = {2'b01, {(MAN_W-2){1'b0}}};
                acc_n.ex  = acc.ex + exp_t'(1);
            end else begin
                acc_n.man = -acc.man;
            end
        end
    end

    // Compare in widened form so extreme exponents cannot wrap.
    always_comb begin
        acc_w = widen(acc_n.ex);
        opd_w = widen(opd.ex);
        if (acc_w >= opd_w) begin
            keep      = acc_n;
            other_man = opd.man;
            gap       = acc_w - opd_w;
        end else begin
            keep      = opd;
            other_man = acc_n.man;
            gap       = opd_w - acc_w;
        end
    end

endmodule

// File: rtl/fadd_sum.sv
module fadd_sum
    import fadd_pkg::*;
(
    input  man_t  keep_man,
    input  man_t  other_man,
    input  exp_t  work_exp,
    output fnum_t result
);
    man_t sum;
    logic ovf;

    always_comb begin
        sum = keep_man + other_man;
        ovf = (keep_man[MAN_W-1] == other_man[MAN_W-1]) &&
              (sum[MAN_W-1] != keep_man[MAN_W-1]);
        if (ovf) begin
            result.man = {keep_man[MAN_W-1], sum[MAN_W-1:1]};
            result.ex  = work_exp + exp_t'(1);
        end else begin
            result.man = sum;
            result.ex  = work_exp;
        end
    end

endmodule

// File: rtl/lazy_fadd.sv
module lazy_fadd
    import fadd_pkg::*;
#(
    parameter int LEFT_CAP  = MAN_W - 1,
    parameter int RIGHT_CAP = MAN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             op_sub,
    input  logic [MAN_W-1:0] acc_man,
    input  logic [EXP_W-1:0] acc_exp,
    input  logic [MAN_W-1:0] opd_man,
    input  logic [EXP_W-1:0] opd_exp,
    output logic             busy,
    output logic             done,
    output logic [MAN_W-1:0] res_man,
    output logic [EXP_W-1:0] res_exp
);
    localparam int CNT_W = $clog2(RIGHT_CAP + 1);

    fstate_t          state;
    fnum_t            keep_q;
    man_t             other_q;
    gap_t             gap_q;
    logic [CNT_W-1:0] lcnt;
    logic [CNT_W-1:0] rcnt;

    fnum_t prep_keep;
    man_t  prep_other;
    gap_t  prep_gap;
    fnum_t sum_res;
    logic  left_ok;
    logic  finish;

    fadd_prep u_prep (
        .op_sub    (op_sub),
        .acc       ('{man: acc_man, ex: acc_exp}),
        .opd       ('{man: opd_man, ex: opd_exp}),
        .keep      (prep_keep),
        .other_man (prep_other),
        .gap       (prep_gap)
    );

    fadd_sum u_sum (
        .keep_man  (keep_q.man),
        .other_man (other_q),
        .work_exp  (keep_q.ex),
        .result    (sum_res)
    );

    always_comb begin
        left_ok = !is_std(keep_q.man) && (lcnt != CNT_W'(LEFT_CAP));
        finish  = (gap_q == '0) || (!left_ok && (rcnt == CNT_W'(RIGHT_CAP)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            keep_q  <= '0;
            other_q <= '0;
            gap_q   <= '0;
            lcnt    <= '0;
            rcnt    <= '0;
            done    <= 1'b0;
            res_man <= '0;
            res_exp <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        keep_q  <= prep_keep;
                        other_q <= prep_other;
                        gap_q   <= prep_gap;
                        lcnt    <= '0;
                        rcnt    <= '0;
                        state   <= ST_ALIGN;
                    end
                end
                ST_ALIGN: begin
                    if (finish) begin
                        res_man <= sum_res.man;
                        res_exp <= sum_res.ex;
                        done    <= 1'b1;
                        state   <= ST_IDLE;
                    end else if (left_ok) begin
                        keep_q.man <= keep_q.man << 1;
                        keep_q.ex  <= keep_q.ex - exp_t'(1);
                        gap_q      <= gap_q - gap_t'(1);
                        lcnt       <= lcnt + CNT_W'(1);
                    end else begin
                        other_q <= man_t'($signed(other_q) >>> 1);
                        gap_q   <= gap_q - gap_t'(1);
                        rcnt    <= rcnt + CNT_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state == ST_ALIGN);

endmodule

// File: rtl/fadd_chk.sv
module fadd_chk
    import fadd_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [MAN_W-1:0] res_man,
    input logic [EXP_W-1:0] res_exp
);
    localparam int MAX_BUSY = 2 * MAN_W;

    int unsigned busy_cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy) busy_cnt <= 0;
        else              busy_cnt <= busy_cnt + 1;
    end

    // R2
    start_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R3
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(res_man) && $stable(res_exp)));

    // R11
    latency_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_cnt < MAX_BUSY));

endmodule

bind lazy_fadd fadd_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .res_man (res_man),
    .res_exp (res_exp)
);

// File: tb/sim_lazy_fadd.sv
module sim_lazy_fadd;

    typedef struct packed {
        logic        sub;
        logic [17:0] am;
        logic [17:0] ae;
        logic [17:0] mm;
        logic [17:0] me;
        logic [17:0] xm;
        logic [17:0] xe;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        // R8 positive overflow, equal exponents
        '{1'b0, 18'h10000, 18'h00001, 18'h10000, 18'h00001, 18'h10000, 18'h00002},
        // R4/R6 right shift of smaller by 2
        '{1'b0, 18'h10000, 18'h00003, 18'h10000, 18'h00001, 18'h14000, 18'h00003},
        // R6 left shift of kept mantissa, then R8 overflow
        '{1'b0, 18'h08000, 18'h00005, 18'h10000, 18'h00004, 18'h10000, 18'h00005},
        // R9 cancellation, no renormalisation
        '{1'b1, 18'h10000, 18'h00000, 18'h10000, 18'h00000, 18'h00000, 18'h00000},
        // R5 most negative negation
        '{1'b1, 18'h20000, 18'h00002, 18'h00000, 18'h00003, 18'h10000, 18'h00003},
        // R6 operand kept, left shift of negative
        '{1'b0, 18'h10000, 18'h00000, 18'h30000, 18'h00001, 18'h30000, 18'h00000},
        // R7 right-shift cap, sign fill
        '{1'b0, 18'h10000, 18'd100,   18'h30000, 18'h00000, 18'h0FFFF, 18'd100},
        // R7 zero kept: 17 left shifts
        '{1'b0, 18'h00000, 18'd50,    18'h10000, 18'h00000, 18'h00000, 18'd33},
        // R10 extreme exponents
        '{1'b0, 18'h10000, 18'h1FFFF, 18'h10000, 18'h20000, 18'h10000, 18'h1FFFF},
        // R8 negative overflow
        '{1'b0, 18'h20000, 18'h00000, 18'h20000, 18'h00000, 18'h20000, 18'h00001},
        // R5 ordinary negate-and-add, tie keeps accumulator
        '{1'b1, 18'h08000, 18'h00002, 18'h10000, 18'h00002, 18'h08000, 18'h00002},
        // R4 negative exponents
        '{1'b0, 18'h10000, 18'h3FFFE, 18'h10000, 18'h3FFFC, 18'h14000, 18'h3FFFE}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        op_sub = 1'b0;
    logic [17:0] acc_man = '0;
    logic [17:0] acc_exp = '0;
    logic [17:0] opd_man = '0;
    logic [17:0] opd_exp = '0;
    logic        busy;
    logic        done;
    logic [17:0] res_man;
    logic [17:0] res_exp;

    int n_chk = 0;
    int n_bad = 0;
    int lat;

    always #2.5 clk = ~clk;

    lazy_fadd u0 (
        .clk(clk), .rst(rst), .start(start), .op_sub(op_sub),
        .acc_man(acc_man), .acc_exp(acc_exp),
        .opd_man(opd_man), .opd_exp(opd_exp),
        .busy(busy), .done(done), .res_man(res_man), .res_exp(res_exp)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic load(input logic s, input logic [17:0] am, ae, mm, me);
        op_sub = s; acc_man = am; acc_exp = ae; opd_man = mm; opd_exp = me;
    endtask

    task automatic run_op(input logic s, input logic [17:0] am, ae, mm, me, output int l);
        @(negedge clk);
        load(s, am, ae, mm, me);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        l = 0;
        while (!done && l < 100) begin
            @(posedge clk); #1;
            l++;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", 32'(busy), 0);
        check("R1 done", 32'(done), 0);
        check("R1 res_man", 32'(res_man), 0);
        check("R1 res_exp", 32'(res_exp), 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i].sub, VECS[i].am, VECS[i].ae, VECS[i].mm, VECS[i].me, lat);
            check($sformatf("R4 vec%0d man", i), 32'(res_man), 32'(VECS[i].xm));
            check($sformatf("R4 vec%0d exp", i), 32'(res_exp), 32'(VECS[i].xe));
        end

        // R11 latency: equal exponents, standardised -> 1
        run_op(1'b0, 18'h10000, 18'h1, 18'h10000, 18'h1, lat);
        check("R11 short latency", 32'(lat), 1);
        // R3 done one cycle, result held
        @(posedge clk); #1;
        check("R3 done width", 32'(done), 0);
        repeat (4) @(posedge clk);
        #1;
        check("R3 hold man", 32'(res_man), 32'h10000);
        check("R3 hold exp", 32'(res_exp), 32'h2);

        // R2 start while busy is ignored; R11 longest latency 36
        @(negedge clk);
        load(1'b0, 18'h00000, 18'd50, 18'h10000, 18'h00000);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 busy after start", 32'(busy), 1);
        lat = 0;
        repeat (3) begin @(posedge clk); #1; lat++; end
        @(negedge clk);
        load(1'b0, 18'h10000, 18'h1, 18'h10000, 18'h1);
        start = 1'b1;
        @(posedge clk); #1; lat++;
        @(negedge clk);
        start = 1'b0;
        while (!done && lat < 100) begin
            @(posedge clk); #1;
            lat++;
        end
        check("R11 long latency", 32'(lat), 36);
        check("R2 ignored start man", 32'(res_man), 0);
        check("R2 ignored start exp", 32'(res_exp), 33);

        // R1 reset during an operation
        @(negedge clk);
        load(1'b0, 18'h00000, 18'd50, 18'h10000, 18'h00000);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", 32'(busy), 0);
        check("R1 man after reset", 32'(res_man), 0);
        check("R1 exp after reset", 32'(res_exp), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule